// File: doc/BRIEF.md
# ADC Conversion Autosequencer

This block drives a multi-channel analog-to-digital converter through a programmed list of channel selections. Software fills a table of 4-bit channel numbers, one per sequencer state, and a conversion count. A start trigger then makes the sequencer visit the states in ascending order. For each state it hands the channel number to an external converter over a start/done handshake, and it stores the returned sample in the result register that has the same index as the state.

The count register holds the number of conversions minus one. It is copied into a down-counter at the trigger, and the counter drops by one after every finished conversion. When the counter is at zero and a conversion finishes, the session ends. In continuous mode the sequencer reloads the counter, goes back to its starting state and starts again at once. In one-shot mode it stays on the last state and ignores triggers until software applies a sequencer reset. A parameter sets the starting state, so two instances can serve as a lower half (state 0) and an upper half (state 8). An end-of-session flag can raise an interrupt, and a small read port lets the host fetch results while conversions go on.

Top module: `adc_autoseq`

## Requirements
- R1: After reset, and after a sequencer reset, the block is idle and `conv_start_o` is low. A `soc_i` pulse in idle makes `conv_start_o` high for exactly one cycle, beginning one cycle after the pulse. `conv_chan_o` then carries the field at the starting state. The field for state k is bits [4k+3:4k] of `chan_sel_i`.
- R2: A session performs exactly `max_conv_i`+1 conversions. The count is copied at the trigger and drops by one after each `conv_done_i`.
- R3: The conversions of a session visit the states starting at the base state and going up by one (modulo 16), and each one issues the channel field of its state.
- R4: With `cont_run_i` high, the conversion that ends a session is followed, with no new trigger, by a new start at the base state with the count reloaded.
- R5: With `cont_run_i` low, no conversion follows the end of a session, and `soc_i` has no effect until `seq_rst_i` is pulsed.
- R6: A `seq_rst_i` pulse returns the state pointer to the base state (parameter `BASE_STATE`, 0 or 8). It also wins over a `soc_i` in the same cycle.
- R7: The sample returned for state k is written to result register k. A read with `rd_en_i` high returns register `rd_addr_i` on `rd_data_o` one cycle later. All result registers read 0 after reset.
- R8: If a converter result and a host read target the same register in the same cycle, the read returns the previous content. The write is held for one cycle and then takes effect.
- R9: With `int_en_i` high, `int_flag_o` is set in the cycle after each end of session. With `int_en_i` low, it is not set.
- R10: `int_flag_o` stays set until a cycle with `int_clr_i` high clears it. A new end of session in the same cycle takes priority over the clear.
- R11: A `soc_i` during a session in progress is ignored: the count and the order of conversions do not change.
- R12: A `seq_rst_i` while a conversion is in progress discards that conversion: a `conv_done_i` that follows writes no result register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| soc_i | input | 1 | Start-of-conversion trigger pulse |
| seq_rst_i | input | 1 | Sequencer reset pulse |
| cont_run_i | input | 1 | 1 = continuous, 0 = one-shot |
| int_en_i | input | 1 | Enables setting of the interrupt flag |
| int_clr_i | input | 1 | Write-one-to-clear strobe for the interrupt flag |
| max_conv_i | input | PTR_W | Number of conversions minus one |
| chan_sel_i | input | 2**PTR_W*CH_W | Channel table, field k at bits [CH_W*k+CH_W-1:CH_W*k] |
| conv_start_o | output | 1 | One-cycle start request to the converter |
| conv_chan_o | output | CH_W | Channel for the current conversion |
| conv_done_i | input | 1 | Converter result valid pulse |
| conv_data_i | input | RES_W | Converter result |
| rd_en_i | input | 1 | Host read request |
| rd_addr_i | input | PTR_W | Result register to read |
| rd_data_o | output | RES_W | Read data, valid one cycle after the request |
| int_flag_o | output | 1 | Sticky end-of-session interrupt flag |

## Verification
A converter result write and a host read can fall in the same cycle, and they can target the same result register. The bench's converter model can issue a read of the exact register being written in the cycle it raises `conv_done_i`. It then expects the value stored before the write, and a later read must show the new sample. The second overlap is a trigger that arrives while a session is busy. This is provoked in the middle of a one-shot session and judged by the scoreboard, which fails on any start that is not queued.

// File: rtl/adcseq_pkg.sv
// Shared types of the autosequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package adcseq_pkg;

    // Control states of the sequencer walker.
    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,   // waiting for a trigger
        SQ_ISSUE = 2'd1,   // start request to the converter
        SQ_WAIT  = 2'd2,   // waiting for the converter result
        SQ_HOLD  = 2'd3    // one-shot session ended, frozen
    } seq_state_e;

endpackage

// File: rtl/adcseq_ctrl.sv
// Sequencer walker. It holds the state pointer and the conversion down-counter,
// issues converter starts and flags finished conversions and session ends.
// Assumes: conv_done_i is a single-cycle pulse; seq_rst_i wins over every other input.
module adcseq_ctrl
    import adcseq_pkg::*;
#(
    parameter int PTR_W      = 4,
    parameter int BASE_STATE = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soc_i,
    input  logic             seq_rst_i,
    input  logic             cont_run_i,
    input  logic [PTR_W-1:0] max_conv_i,
    input  logic             conv_done_i,
    output logic             conv_start_o,
    output logic [PTR_W-1:0] ptr_o,
    output logic             wr_valid_o,
    output logic             eos_o
);

    localparam logic [PTR_W-1:0] BASE = PTR_W'(BASE_STATE);

    seq_state_e       st;
    logic [PTR_W-1:0] cnt;
    logic [PTR_W-1:0] ptr;
    logic             fin;
    logic             last;

    // A conversion counts as finished only if no sequencer reset discards it.
    assign fin  = (st == SQ_WAIT) && conv_done_i && !seq_rst_i;
    assign last = (cnt == '0);

    // Walks the states, loads and counts down, reloads or freezes at the end.
    always_ff @(posedge clk) begin
        if (!rst_n || seq_rst_i) begin
            st  <= SQ_IDLE;
            ptr <= BASE;
            cnt <= '0;
        end else begin
            case (st)
                SQ_IDLE: if (soc_i) begin
                    cnt <= max_conv_i;
                    ptr <= BASE;
                    st  <= SQ_ISSUE;
                end
                SQ_ISSUE: st <= SQ_WAIT;
                SQ_WAIT: if (conv_done_i) begin
                    if (!last) begin
                        cnt <= cnt - 1'b1;
                        ptr <= ptr + 1'b1;
                        st  <= SQ_ISSUE;
                    end else if (cont_run_i) begin
                        cnt <= max_conv_i;
                        ptr <= BASE;
                        st  <= SQ_ISSUE;
                    end else begin
                        st  <= SQ_HOLD;
                    end
                end
                SQ_HOLD: st <= SQ_HOLD;
                default: st <= SQ_IDLE;
            endcase
        end
    end

    assign conv_start_o = (st == SQ_ISSUE);
    assign ptr_o        = ptr;
    assign wr_valid_o   = fin;
    assign eos_o        = fin && last;

    assert_start_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start_o |=> !conv_start_o);

    assert_count_down_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (fin && !last) |=> (cnt == $past(cnt) - 1'b1));

    assert_ptr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (fin && !last) |=> (ptr == $past(ptr) + 1'b1) && conv_start_o);

    assert_reload_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (fin && last && cont_run_i) |=> (ptr == BASE) && (cnt == $past(max_conv_i)) && conv_start_o);

    assert_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st == SQ_HOLD && !seq_rst_i) |=> (st == SQ_HOLD) && $stable(ptr) && !conv_start_o);

    assert_seq_reset_R6: assert property (@(posedge clk) disable iff (!rst_n)
        seq_rst_i |=> (ptr == BASE) && (st == SQ_IDLE) && !conv_start_o);

    assert_busy_soc_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (st == SQ_WAIT && soc_i && !conv_done_i && !seq_rst_i) |=> $stable(cnt) && $stable(ptr));

    assert_discard_R12: assert property (@(posedge clk) disable iff (!rst_n)
        seq_rst_i |-> !wr_valid_o);

endmodule

// File: rtl/adcseq_results.sv
// Result register file, indexed by sequencer state, with a host read port.
// A result that meets a same-cycle read of its register is parked for one
// cycle, so the read returns the previous content.
// Assumes: results arrive at least two cycles apart (start/done handshake).
module adcseq_results #(
    parameter int PTR_W = 4,
    parameter int RES_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_valid_i,
    input  logic [PTR_W-1:0] wr_idx_i,
    input  logic [RES_W-1:0] wr_data_i,
    input  logic             rd_en_i,
    input  logic [PTR_W-1:0] rd_addr_i,
    output logic [RES_W-1:0] rd_data_o
);

    localparam int DEPTH = 2 ** PTR_W;

    logic [RES_W-1:0] mem [DEPTH];
    logic             clash;
    logic             pend_v;
    logic [PTR_W-1:0] pend_idx;
    logic [RES_W-1:0] pend_data;
    logic             commit_v;
    logic [PTR_W-1:0] commit_idx;
    logic [RES_W-1:0] commit_data;

    assign clash       = wr_valid_i && rd_en_i && (rd_addr_i == wr_idx_i);
    assign commit_v    = pend_v || (wr_valid_i && !clash);
    assign commit_idx  = pend_v ? pend_idx  : wr_idx_i;
    assign commit_data = pend_v ? pend_data : wr_data_i;

    // Parks a colliding write for exactly one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_v    <= 1'b0;
            pend_idx  <= '0;
            pend_data <= '0;
        end else begin
            pend_v    <= clash;
            pend_idx  <= wr_idx_i;
            pend_data <= wr_data_i;
        end
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        logic [RES_W-1:0] q;
        // Stores the committed result aimed at this entry.
        always_ff @(posedge clk) begin
            if (!rst_n)
                q <= '0;
            else if (commit_v && commit_idx == PTR_W'(i))
                q <= commit_data;
        end
        assign mem[i] = q;
    end

    // Registers the host read data.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_data_o <= '0;
        else if (rd_en_i)
            rd_data_o <= mem[rd_addr_i];
    end

    assert_park_clash_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clash |=> pend_v && (pend_idx == $past(wr_idx_i)));

    assert_park_alone_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pend_v |-> !wr_valid_i);

    assert_write_lands_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid_i && !rd_en_i && !pend_v) |=> (mem[$past(wr_idx_i)] == $past(wr_data_i)));

endmodule

// File: rtl/adcseq_irq.sv
// Sticky end-of-session interrupt flag with write-one-to-clear.
// Assumes: eos_i is a single-cycle pulse; a set beats a same-cycle clear.
module adcseq_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic eos_i,
    input  logic int_en_i,
    input  logic int_clr_i,
    output logic flag_o
);

    // Sets on an enabled session end, clears on the host strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag_o <= 1'b0;
        else if (eos_i && int_en_i)
            flag_o <= 1'b1;
        else if (int_clr_i)
            flag_o <= 1'b0;
    end

    assert_flag_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (eos_i && int_en_i) |=> flag_o);

    assert_flag_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag_o && !(eos_i && int_en_i)) |=> !flag_o);

    assert_flag_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && !int_clr_i) |=> flag_o);

endmodule

// File: rtl/adc_autoseq.sv
// Top of the conversion autosequencer: walker, result file and interrupt flag.
// Assumes: an external converter answers each conv_start_o with a single conv_done_i.
module adc_autoseq #(
    parameter int PTR_W      = 4,
    parameter int CH_W       = 4,
    parameter int RES_W      = 12,
    parameter int BASE_STATE = 0
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        soc_i,
    input  logic                        seq_rst_i,
    input  logic                        cont_run_i,
    input  logic                        int_en_i,
    input  logic                        int_clr_i,
    input  logic [PTR_W-1:0]            max_conv_i,
    input  logic [(2**PTR_W)*CH_W-1:0]  chan_sel_i,
    output logic                        conv_start_o,
    output logic [CH_W-1:0]             conv_chan_o,
    input  logic                        conv_done_i,
    input  logic [RES_W-1:0]            conv_data_i,
    input  logic                        rd_en_i,
    input  logic [PTR_W-1:0]            rd_addr_i,
    output logic [RES_W-1:0]            rd_data_o,
    output logic                        int_flag_o
);

    logic [PTR_W-1:0] ptr;
    logic             wr_valid;
    logic             eos;

    adcseq_ctrl #(.PTR_W(PTR_W), .BASE_STATE(BASE_STATE)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .soc_i        (soc_i),
        .seq_rst_i    (seq_rst_i),
        .cont_run_i   (cont_run_i),
        .max_conv_i   (max_conv_i),
        .conv_done_i  (conv_done_i),
        .conv_start_o (conv_start_o),
        .ptr_o        (ptr),
        .wr_valid_o   (wr_valid),
        .eos_o        (eos)
    );

    // Picks the channel field of the current state.
    assign conv_chan_o = chan_sel_i[int'(ptr)*CH_W +: CH_W];

    adcseq_results #(.PTR_W(PTR_W), .RES_W(RES_W)) u_results (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_valid_i (wr_valid),
        .wr_idx_i   (ptr),
        .wr_data_i  (conv_data_i),
        .rd_en_i    (rd_en_i),
        .rd_addr_i  (rd_addr_i),
        .rd_data_o  (rd_data_o)
    );

    adcseq_irq u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .eos_i     (eos),
        .int_en_i  (int_en_i),
        .int_clr_i (int_clr_i),
        .flag_o    (int_flag_o)
    );

endmodule

// File: tb/test_adc_autoseq.sv
// Scoreboard bench. Test tasks queue expected {state, channel} items; a
// monitor/converter model pops them at each start request, answers with a
// result and records the expected content of the result registers.
module test_adc_autoseq;

    localparam int PTR_W = 4;
    localparam int CH_W  = 4;
    localparam int RES_W = 12;
    localparam int BASE  = 8;
    localparam int DEPTH = 2 ** PTR_W;

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic                   soc_i = 1'b0;
    logic                   seq_rst_i = 1'b0;
    logic                   cont_run_i = 1'b0;
    logic                   int_en_i = 1'b0;
    logic                   int_clr_i = 1'b0;
    logic [PTR_W-1:0]       max_conv_i = '0;
    logic [DEPTH*CH_W-1:0]  chan_sel_i = '0;
    logic                   conv_start_o;
    logic [CH_W-1:0]        conv_chan_o;
    logic                   conv_done_i = 1'b0;
    logic [RES_W-1:0]       conv_data_i = '0;
    logic                   rd_en_i = 1'b0;
    logic [PTR_W-1:0]       rd_addr_i = '0;
    logic [RES_W-1:0]       rd_data_o;
    logic                   int_flag_o;

    adc_autoseq #(.PTR_W(PTR_W), .CH_W(CH_W), .RES_W(RES_W), .BASE_STATE(BASE)) i_adc_autoseq (
        .clk(clk), .rst_n(rst_n), .soc_i(soc_i), .seq_rst_i(seq_rst_i),
        .cont_run_i(cont_run_i), .int_en_i(int_en_i), .int_clr_i(int_clr_i),
        .max_conv_i(max_conv_i), .chan_sel_i(chan_sel_i),
        .conv_start_o(conv_start_o), .conv_chan_o(conv_chan_o),
        .conv_done_i(conv_done_i), .conv_data_i(conv_data_i),
        .rd_en_i(rd_en_i), .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o),
        .int_flag_o(int_flag_o)
    );

    always #5 clk = ~clk;

    int checks = 0;
    int fails = 0;
    int starts_seen = 0;
    bit resp_busy = 1'b0;
    bit discard = 1'b0;
    bit collide = 1'b0;
    bit finished = 1'b0;
    logic [7:0] serial = '0;
    logic [7:0] exp_q[$];
    logic [RES_W-1:0] exp_res [DEPTH];

    function automatic logic [CH_W-1:0] fld(input int k);
        return CH_W'((k * 7 + 3) % 16);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Driver: queues the expected conversions of n starts from the base state.
    task automatic push_session(input int maxc, input int n);
        for (int j = 0; j < n; j++) begin
            int idx;
            idx = (BASE + (j % (maxc + 1))) % DEPTH;
            exp_q.push_back({4'(idx), fld(idx)});
        end
    endtask

    task automatic pulse_soc();
        @(negedge clk); soc_i = 1'b1;
        @(negedge clk); soc_i = 1'b0;
    endtask

    task automatic pulse_rst();
        @(negedge clk); seq_rst_i = 1'b1;
        @(negedge clk); seq_rst_i = 1'b0;
    endtask

    task automatic wait_idle();
        wait (exp_q.size() == 0 && !resp_busy);
        repeat (4) @(negedge clk);
    endtask

    task automatic rd_chk(input string tag, input int idx, input logic [RES_W-1:0] exp);
        @(negedge clk); rd_en_i = 1'b1; rd_addr_i = PTR_W'(idx);
        @(negedge clk); rd_en_i = 1'b0;
        chk(tag, 32'(rd_data_o), 32'(exp));
    endtask

    // Monitor and converter model: pops, compares, answers two cycles later.
    initial begin
        forever begin
            @(negedge clk);
            while (conv_start_o) begin
                logic [7:0] item;
                logic [CH_W-1:0] ch;
                logic [RES_W-1:0] data;
                logic [RES_W-1:0] old;
                int idx;
                resp_busy = 1'b1;
                starts_seen++;
                ch = conv_chan_o;
                idx = 0;
                if (exp_q.size() == 0) begin
                    checks++; fails++;
                    $display("FAIL R5/R11 unexpected start actual=chan %0h expected=no start", ch);
                end else begin
                    item = exp_q.pop_front();
                    idx = int'(item[7:4]);
                    chk("R3 channel order", 32'(ch), 32'(item[3:0]));
                end
                repeat (2) @(negedge clk);
                serial = serial + 8'd1;
                data = {ch, serial};
                conv_data_i = data;
                conv_done_i = 1'b1;
                old = exp_res[idx];
                if (collide) begin
                    rd_en_i = 1'b1;
                    rd_addr_i = PTR_W'(idx);
                end
                @(negedge clk);
                conv_done_i = 1'b0;
                if (collide) begin
                    rd_en_i = 1'b0;
                    collide = 1'b0;
                    chk("R8 read during write returns old", 32'(rd_data_o), 32'(old));
                end
                if (!discard) exp_res[idx] = data;
                resp_busy = 1'b0;
            end
        end
    end

    // Watchdog: an expired run counts as a failure and still reports.
    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int s0;
        for (int k = 0; k < DEPTH; k++) begin
            chan_sel_i[k*CH_W +: CH_W] = fld(k);
            exp_res[k] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle after reset", 32'(conv_start_o), 32'd0);
        chk("R10 flag clear after reset", 32'(int_flag_o), 32'd0);
        rd_chk("R7 result zero after reset", BASE, '0);

        // One-shot session of seven conversions with interrupt enabled.
        int_en_i = 1'b1; cont_run_i = 1'b0; max_conv_i = 4'd6;
        s0 = starts_seen;
        push_session(6, 7);
        pulse_soc();
        chk("R1 start one cycle after trigger", 32'(conv_start_o), 32'd1);
        chk("R1 first channel from base field", 32'(conv_chan_o), 32'(fld(BASE)));
        wait_idle();
        chk("R2 seven conversions for count 6", 32'(starts_seen - s0), 32'd7);
        chk("R9 flag set at session end", 32'(int_flag_o), 32'd1);
        for (int k = 0; k < 7; k++) rd_chk("R7 result in state register", BASE + k, exp_res[BASE + k]);
        rd_chk("R2 state past the end untouched", BASE + 7, '0);

        // Frozen: trigger ignored, flag sticky, then cleared.
        s0 = starts_seen;
        pulse_soc();
        repeat (10) @(negedge clk);
        chk("R5 trigger ignored while frozen", 32'(starts_seen - s0), 32'd0);
        chk("R10 flag still set", 32'(int_flag_o), 32'd1);
        @(negedge clk); int_clr_i = 1'b1;
        @(negedge clk); int_clr_i = 1'b0;
        chk("R10 flag cleared by strobe", 32'(int_flag_o), 32'd0);

        // Sequencer reset, then a three-conversion session with a busy trigger.
        pulse_rst();
        int_en_i = 1'b0; max_conv_i = 4'd2;
        s0 = starts_seen;
        push_session(2, 3);
        pulse_soc();
        chk("R6 restart at base after reset", 32'(conv_chan_o), 32'(fld(BASE)));
        pulse_soc();
        wait_idle();
        repeat (6) @(negedge clk);
        chk("R11 busy trigger adds no conversion", 32'(starts_seen - s0), 32'd3);
        chk("R9 flag stays low when disabled", 32'(int_flag_o), 32'd0);
        for (int k = 0; k < 3; k++) rd_chk("R7 result of second session", BASE + k, exp_res[BASE + k]);

        // Continuous mode, two per round, stopped by a reset mid-conversion.
        pulse_rst();
        int_en_i = 1'b1; cont_run_i = 1'b1; max_conv_i = 4'd1;
        s0 = starts_seen;
        push_session(1, 7);
        pulse_soc();
        wait (starts_seen == s0 + 7);
        @(negedge clk); seq_rst_i = 1'b1; discard = 1'b1;
        @(negedge clk); seq_rst_i = 1'b0; cont_run_i = 1'b0;
        wait (!resp_busy);
        repeat (8) @(negedge clk);
        discard = 1'b0;
        chk("R4 restarts without trigger", 32'(starts_seen - s0), 32'd7);
        chk("R9 flag set in continuous mode", 32'(int_flag_o), 32'd1);
        rd_chk("R12 discarded result not written", BASE, exp_res[BASE]);
        rd_chk("R4 second state of last round", BASE + 1, exp_res[BASE + 1]);

        // Collision of a result write with a host read of the same register.
        pulse_rst();
        max_conv_i = 4'd0;
        collide = 1'b1;
        s0 = starts_seen;
        push_session(0, 1);
        pulse_soc();
        wait_idle();
        chk("R2 single conversion for count 0", 32'(starts_seen - s0), 32'd1);
        rd_chk("R8 held write lands afterwards", BASE, exp_res[BASE]);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule